// File: doc/BRIEF.md
# Serial Interrupt Bus Host Controller

This block is the host end of a single-wire serial interrupt bus. The wire is open-drain and is sampled on the bus clock. The controller opens each cycle with a low start pulse. It then walks a fixed train of three-clock data frames and reads the wire once per frame. Each reading is folded into a register of interrupt levels: the legacy IRQ lines, a channel-check bit, four shared PCI interrupt lines and a system-management request.

Once the last frame has passed, the host pulls the wire low again to mark the end of the cycle. The length of that closing pulse tells every agent how the next cycle will begin:
- In continuous mode the host starts every cycle by itself.
- In quiet mode the host stays idle until an agent pulls the wire low. The host then stretches that pulse into a full start pulse.

The wire is modelled as a sensed level `line_i` and a drive-low enable. The board supplies the pull-up.

Top module: `sirq_host`

## Requirements
- R1: While `rst_n` is low, `drive_low_o` is 0 and every decoded output is 0. The mode for the first cycle after reset is continuous.
- R2: In continuous mode the host begins a cycle without any outside trigger. It holds `drive_low_o` high for exactly START_CLKS consecutive clocks (4, 6 or 8; default 4).
- R3: Number the clocks from 1, where clock 1 is the first clock after the start pulse is released. The wire is read for data frame N on clock 3N-1. A low reading sets that frame's output bit to 1, and a high reading clears it to 0. The new value stays in place until that same frame is read in a later cycle.
- R4: The frames map to output bits as follows:
  - Frames 2, 4–8, 10–13, 15 and 16 drive `irq_o[N-1]`.
  - Frame 17 drives `iochck_o`.
  - Frames 18–21 drive `intx_o[0]` to `intx_o[3]`.
  - Frames 1, 9 and 14 are unassigned and have no effect, so `irq_o` bits 0, 8 and 13 stay 0.
  - A low wire on any clock that is not a frame's read clock has no effect.
- R5: A low reading on frame 3 raises `smi_pulse_o` for exactly one clock, on the clock after the read. No other frame raises it.
- R6: The closing pulse starts on clock 3*NUM_FRAMES+2. It lasts 3 clocks if `cont_mode_i` is 1 on the last data-frame clock, and 2 clocks otherwise.
- R7: After a 3-clock closing pulse, the host leaves the wire released for exactly one clock. It then starts the next cycle on its own, as in R2.
- R8: After a 2-clock closing pulse, the host never starts a cycle by itself. When an agent holds the wire low for one clock from the second released clock onward, the host drives for START_CLKS-1 further clocks, so the wire is low for START_CLKS clocks in total.
- R9: In quiet mode, a low wire on the first clock after the closing pulse is released does not start a cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low synchronous reset |
| line_i | input | 1 | Sensed level of the serial interrupt wire |
| cont_mode_i | input | 1 | 1 selects continuous mode for the next cycle, 0 selects quiet mode |
| drive_low_o | output | 1 | 1 pulls the wire low |
| irq_o | output | 16 | Latched legacy IRQ levels, 1 = asserted |
| iochck_o | output | 1 | Latched channel-check level, 1 = asserted |
| intx_o | output | 4 | Latched PCI INTA..INTD levels, 1 = asserted |
| smi_pulse_o | output | 1 | One-clock system-management request |

## Verification
The controller keeps a single frame/phase position. If that position slips by even one clock, every reading shifts onto a neighbouring slot. The bench would then see the wrong bit in the decoded vector at the end of the same cycle. It would also see the closing pulse begin away from clock 3*NUM_FRAMES+2. A wrong start or stop counter shows up directly as a wrong pulse length on `drive_low_o`. A wrong mode bit shows up as either a spurious self-started cycle during a quiet-mode wait, or a missing one after a 3-clock closing pulse. Both are observable within a few clocks of the release.

// File: rtl/sirq_pkg.sv
package sirq_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_START,
        ST_FRAMES,
        ST_STOP,
        ST_RECOV
    } sq_state_e;

    typedef enum logic {
        MODE_QUIET = 1'b0,
        MODE_CONT  = 1'b1
    } bus_mode_e;

    typedef enum logic [2:0] {
        SLOT_NONE,
        SLOT_IRQ,
        SLOT_SMI,
        SLOT_IOCHK,
        SLOT_INTX
    } slot_kind_e;

    typedef struct packed {
        slot_kind_e kind;
        logic [3:0] idx;
    } slot_t;

    // Frame number to destination.
    // Legacy IRQ k sits in frame k+1; IRQ0, IRQ2, IRQ8 and IRQ13 have no slot.
    function automatic slot_t slot_of(input int unsigned frame);
        slot_t s;
        s.kind = SLOT_NONE;
        s.idx  = 4'd0;
        if (frame == 3) begin
            s.kind = SLOT_SMI;
        end else if (frame == 17) begin
            s.kind = SLOT_IOCHK;
        end else if (frame >= 18 && frame <= 21) begin
            s.kind = SLOT_INTX;
            s.idx  = 4'(frame - 18);
        end else if (frame >= 2 && frame <= 16 && frame != 9 && frame != 14) begin
            s.kind = SLOT_IRQ;
            s.idx  = 4'(frame - 1);
        end
        return s;
    endfunction

endpackage

// File: rtl/sirq_seq.sv
module sirq_seq
    import sirq_pkg::*;
#(
    parameter int NUM_FRAMES = 21,
    parameter int START_CLKS = 4,
    parameter int FW = $clog2(NUM_FRAMES + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          line_i,
    input  logic          cont_mode_i,
    output logic          drive_o,
    output logic          samp_stb_o,
    output logic [FW-1:0] samp_frame_o
);

    localparam int CMAX = (START_CLKS > 3) ? START_CLKS : 3;
    localparam int CW   = $clog2(CMAX + 1);

    typedef struct packed {
        sq_state_e     state;
        bus_mode_e     mode;
        logic [CW-1:0] cnt;
        logic [FW-1:0] frm;
        logic [1:0]    ph;
    } seq_t;

    seq_t seq_d, seq_q;
    logic [CW-1:0] stop_len;

    always_comb begin
        seq_d    = seq_q;
        stop_len = (seq_q.mode == MODE_CONT) ? CW'(3) : CW'(2);
        case (seq_q.state)
            ST_IDLE: begin
                if (seq_q.mode == MODE_CONT) begin
                    seq_d.state = ST_START;
                    seq_d.cnt   = CW'(1);
                end else if (!line_i) begin
                    // the agent's own low clock counts as the first one
                    seq_d.state = ST_START;
                    seq_d.cnt   = CW'(2);
                end
            end
            ST_START: begin
                if (seq_q.cnt == CW'(START_CLKS)) begin
                    seq_d.state = ST_FRAMES;
                    seq_d.frm   = '0;
                    seq_d.ph    = 2'd2;
                end else begin
                    seq_d.cnt = seq_q.cnt + CW'(1);
                end
            end
            ST_FRAMES: begin
                if (seq_q.frm == FW'(NUM_FRAMES) && seq_q.ph == 2'd2) begin
                    seq_d.state = ST_STOP;
                    seq_d.cnt   = CW'(1);
                    seq_d.mode  = cont_mode_i ? MODE_CONT : MODE_QUIET;
                end else if (seq_q.ph == 2'd2) begin
                    seq_d.ph  = 2'd0;
                    seq_d.frm = seq_q.frm + FW'(1);
                end else begin
                    seq_d.ph = seq_q.ph + 2'd1;
                end
            end
            ST_STOP: begin
                if (seq_q.cnt == stop_len) begin
                    seq_d.state = ST_RECOV;
                end else begin
                    seq_d.cnt = seq_q.cnt + CW'(1);
                end
            end
            ST_RECOV: begin
                if (seq_q.mode == MODE_CONT) begin
                    seq_d.state = ST_START;
                    seq_d.cnt   = CW'(1);
                end else begin
                    seq_d.state = ST_IDLE;
                end
            end
            default: seq_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            seq_q.state <= ST_IDLE;
            seq_q.mode  <= MODE_CONT;
            seq_q.cnt   <= '0;
            seq_q.frm   <= '0;
            seq_q.ph    <= '0;
        end else begin
            seq_q <= seq_d;
        end
    end

    assign drive_o      = (seq_q.state == ST_START) || (seq_q.state == ST_STOP);
    assign samp_stb_o   = (seq_q.state == ST_FRAMES) && (seq_q.ph == 2'd0);
    assign samp_frame_o = seq_q.frm;

    // R2
    start_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_q.state == ST_FRAMES && $past(seq_q.state) == ST_START)
            |-> ($past(seq_q.cnt) == CW'(START_CLKS)));

    // R6
    stop_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_q.state == ST_RECOV)
            |-> ($past(seq_q.cnt) == ((seq_q.mode == MODE_CONT) ? CW'(3) : CW'(2))));

    // R6
    stop_at_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_q.state == ST_STOP && $past(seq_q.state) == ST_FRAMES)
            |-> ($past(seq_q.frm) == FW'(NUM_FRAMES)));

endmodule

// File: rtl/sirq_decode.sv
module sirq_decode
    import sirq_pkg::*;
#(
    parameter int NUM_FRAMES = 21,
    parameter int FW = $clog2(NUM_FRAMES + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          line_i,
    input  logic          samp_stb_i,
    input  logic [FW-1:0] samp_frame_i,
    output logic [15:0]   irq_o,
    output logic          iochck_o,
    output logic [3:0]    intx_o,
    output logic          smi_pulse_o
);

    typedef struct packed {
        logic [15:0] irq;
        logic        iochk;
        logic [3:0]  intx;
        logic        smi;
    } dec_t;

    dec_t  dec_d, dec_q;
    slot_t slot;
    logic  level;

    always_comb begin
        dec_d     = dec_q;
        dec_d.smi = 1'b0;
        level     = ~line_i;
        slot      = slot_of(int'(samp_frame_i));
        if (samp_stb_i && samp_frame_i <= FW'(NUM_FRAMES)) begin
            case (slot.kind)
                SLOT_IRQ:   dec_d.irq[slot.idx]       = level;
                SLOT_SMI:   dec_d.smi                 = level;
                SLOT_IOCHK: dec_d.iochk               = level;
                SLOT_INTX:  dec_d.intx[slot.idx[1:0]] = level;
                default:    ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dec_q <= '0;
        end else begin
            dec_q <= dec_d;
        end
    end

    assign irq_o       = dec_q.irq;
    assign iochck_o    = dec_q.iochk;
    assign intx_o      = dec_q.intx;
    assign smi_pulse_o = dec_q.smi;

    // R3
    samp_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        samp_stb_i |-> (samp_frame_i != '0 && samp_frame_i <= FW'(NUM_FRAMES)));

    // R5
    smi_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        smi_pulse_o |=> !smi_pulse_o);

    // R4
    unassigned_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_q.irq[0] == 1'b0) && (dec_q.irq[8] == 1'b0) && (dec_q.irq[13] == 1'b0));

endmodule

// File: rtl/sirq_host.sv
module sirq_host
    import sirq_pkg::*;
#(
    parameter int NUM_FRAMES = 21,
    parameter int START_CLKS = 4
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        line_i,
    input  logic        cont_mode_i,
    output logic        drive_low_o,
    output logic [15:0] irq_o,
    output logic        iochck_o,
    output logic [3:0]  intx_o,
    output logic        smi_pulse_o
);

    localparam int FW = $clog2(NUM_FRAMES + 1);

    logic          samp_stb;
    logic [FW-1:0] samp_frame;

    sirq_seq #(
        .NUM_FRAMES(NUM_FRAMES),
        .START_CLKS(START_CLKS),
        .FW        (FW)
    ) u_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .line_i      (line_i),
        .cont_mode_i (cont_mode_i),
        .drive_o     (drive_low_o),
        .samp_stb_o  (samp_stb),
        .samp_frame_o(samp_frame)
    );

    sirq_decode #(
        .NUM_FRAMES(NUM_FRAMES),
        .FW        (FW)
    ) u_dec (
        .clk         (clk),
        .rst_n       (rst_n),
        .line_i      (line_i),
        .samp_stb_i  (samp_stb),
        .samp_frame_i(samp_frame),
        .irq_o       (irq_o),
        .iochck_o    (iochck_o),
        .intx_o      (intx_o),
        .smi_pulse_o (smi_pulse_o)
    );

    // R1
    reset_quiet_chk: assert property (@(posedge clk)
        (!rst_n && $past(!rst_n)) |-> (!drive_low_o && irq_o == '0 && !smi_pulse_o));

endmodule

// File: tb/tb_sirq_host.sv
`timescale 1ns/1ps
module tb_sirq_host;

    localparam int NF = 21;
    localparam int SC = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cont_mode = 1'b1;
    logic        agent_low = 1'b0;
    logic        line;
    logic        drive_low;
    logic [15:0] irq;
    logic        iochck;
    logic [3:0]  intx;
    logic        smi;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 0;

    always #10 clk = ~clk;

    assign line = !(drive_low || agent_low);

    sirq_host #(.NUM_FRAMES(NF), .START_CLKS(SC)) dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .line_i     (line),
        .cont_mode_i(cont_mode),
        .drive_low_o(drive_low),
        .irq_o      (irq),
        .iochck_o   (iochck),
        .intx_o     (intx),
        .smi_pulse_o(smi)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic logic [20:0] exp_vec(input logic [32:1] pat);
        logic [15:0] e_irq = '0;
        for (int n = 2; n <= 16; n++)
            if (n != 3 && n != 9 && n != 14) e_irq[n-1] = pat[n];
        return {pat[21:18], pat[17], e_irq};
    endfunction

    // One bus cycle: start, frames with pattern, stop; returns at first released clock after stop.
    task automatic run_cycle(input logic [32:1] pat, input bit next_cont,
                             input bit quiet_start, input int exp_gap, input bit noise);
        int hi, gap, smi_cnt, self_start;
        if (quiet_start) begin
            self_start = 0;
            for (int i = 0; i < 6; i++) begin
                if (drive_low) self_start++;
                @(negedge clk);
            end
            chk(self_start == 0, "R8", "host self-started in quiet mode", self_start, 0);
            agent_low = 1'b1;
            @(negedge clk);
            agent_low = 1'b0;
            hi = 0;
            while (drive_low) begin hi++; @(negedge clk); end
            chk(hi == SC - 1, "R8", "host extension of agent start", hi, SC - 1);
        end else begin
            gap = 0;
            while (!drive_low && gap < 40) begin gap++; @(negedge clk); end
            if (exp_gap > 0)
                chk(gap == exp_gap, "R7", "released clocks before self start", gap, exp_gap);
            hi = 0;
            while (drive_low) begin hi++; @(negedge clk); end
            chk(hi == SC, "R2", "start pulse length", hi, SC);
        end
        cont_mode = next_cont;
        smi_cnt = 0;
        for (int k = 1; k <= 3 * NF + 1; k++) begin
            agent_low = (k % 3 == 2) ? pat[(k + 1) / 3] : noise;
            @(negedge clk);
            if (smi) smi_cnt++;
        end
        agent_low = 1'b0;
        chk(drive_low == 1'b1, "R6", "stop starts at clock 3*NF+2", drive_low, 1);
        hi = 0;
        while (drive_low) begin hi++; @(negedge clk); end
        chk(hi == (next_cont ? 3 : 2), "R6", "stop pulse length", hi, next_cont ? 3 : 2);
        chk({intx, iochck, irq} == exp_vec(pat), noise ? "R4" : "R3",
            "decoded vector", {intx, iochck, irq}, exp_vec(pat));
        chk(smi_cnt == (pat[3] ? 1 : 0), "R5", "smi pulse clocks", smi_cnt, pat[3] ? 1 : 0);
    endtask

    initial begin
        logic [32:1] p;
        logic [31:0] lfsr;
        repeat (4) @(negedge clk);
        // R1
        chk(drive_low == 1'b0, "R1", "drive in reset", drive_low, 0);
        chk({intx, iochck, irq, smi} == '0, "R1", "outputs in reset", {intx, iochck, irq, smi}, 0);
        rst_n = 1'b1;

        // R2 R3: first cycle after reset is continuous
        run_cycle({11'h0, 21'h1FFFFF}, 1'b1, 1'b0, 0, 1'b0);
        run_cycle('0, 1'b1, 1'b0, 1, 1'b0);
        // R4: walking single frame, including unassigned slots
        for (int n = 1; n <= NF; n++) begin
            p = '0;
            p[n] = 1'b1;
            run_cycle(p, 1'b1, 1'b0, 1, 1'b0);
        end
        // R4: low only on turnaround/recovery clocks has no effect
        run_cycle({11'h0, 21'h0AAAAA}, 1'b1, 1'b0, 1, 1'b0);
        run_cycle('0, 1'b1, 1'b0, 1, 1'b1);
        // R6: switch to quiet
        run_cycle({11'h0, 21'h155555}, 1'b0, 1'b0, 1, 1'b0);
        // R9: early low right after stop release is ignored
        agent_low = 1'b1;
        @(negedge clk);
        agent_low = 1'b0;
        begin
            int early = 0;
            for (int i = 0; i < 5; i++) begin
                if (drive_low) early++;
                @(negedge clk);
            end
            chk(early == 0, "R9", "start after early low", early, 0);
        end
        // R8: agent-started cycles
        run_cycle({11'h0, 21'h0F0F0F}, 1'b0, 1'b1, 0, 1'b0);
        run_cycle({11'h0, 21'h13579B}, 1'b1, 1'b1, 0, 1'b0);
        // R7 R3: continuous again with pseudo-random patterns
        lfsr = 32'hACE1_2468;
        for (int i = 0; i < 12; i++) begin
            lfsr = lfsr ^ (lfsr << 13);
            lfsr = lfsr ^ (lfsr >> 17);
            lfsr = lfsr ^ (lfsr << 5);
            run_cycle({11'h0, lfsr[20:0]}, 1'b1, 1'b0, 1, 1'b0);
        end
        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

endmodule